// File: doc/BRIEF.md
# Display Mode Register Interface

This block is the register front end of a linear framebuffer display controller. A host reaches it over a simple synchronous request bus and sees two windows, chosen per request: a mode window of 16-bit registers (enable, horizontal and vertical resolution, colour depth, virtual line width, horizontal and vertical panning offsets), and an extension window of 32-bit registers that holds a framebuffer byte-order flag. Inside the mode window, the register index is the byte address shifted right by one, so each register takes two bytes. The low data byte belongs to the even byte address, which gives a little-endian layout.

Two indices of the mode window never show what was stored in them. Index 0 always answers a fixed identity code. The last index (NUM_REGS-1) answers the framebuffer size in 64 KiB units. Indices past the array read as all ones, and writes to them are discarded. In the extension window, offset 0 answers the window size, offset 4 holds the byte order, and every other offset reads as zero. The stored register values and the byte-order flag leave the block in parallel so the scan-out logic can use them.

Each access is accepted in a single cycle. A response state machine has three states: RSP_IDLE (no response), RSP_MODE (a mode-window read is being returned) and RSP_EXT (an extension read is being returned). On every edge, a read request moves it to RSP_MODE or RSP_EXT depending on its window. Any other cycle (idle, or a write) moves it to RSP_IDLE. Reset forces RSP_IDLE.

Top module: `dispmode_regs`

## Requirements
- R1: After reset every mode register, the exported register vector, the byte-order flag and `rsp_valid` are zero. A zero flag means little-endian.
- R2: A mode-window write to an in-range index (address bits [ADDR_W-1:1]) updates that register on the next edge, and bit 0 of the address is ignored. `req_be[0]` enables bits 7:0 (the even byte) and `req_be[1]` enables bits 15:8 (the odd byte). The new value shows in `regs_flat[16*i +: 16]` one cycle after the request.
- R3: A mode-window read of an in-range index other than 0 and NUM_REGS-1 returns the stored value zero-extended to 32 bits, one cycle after the request.
- R4: A read of index 0 returns ID_VALUE, even after that register has been written.
- R5: A read of index NUM_REGS-1 returns FB_BYTES/65536, even after that register has been written.
- R6: A mode-window read of an index at or above NUM_REGS returns 32'h0000FFFF.
- R7: A mode-window write to an index at or above NUM_REGS changes no exported register.
- R8: An extension read at byte offset 0 returns EXT_SIZE. An extension read at any offset other than 0 and 4 returns zero.
- R9: An extension write at offset 4 sets the flag when the data is 32'hBEBEBEBE and clears it when the data is 32'h1E1E1E1E. Any other data at offset 4, and any write at another extension offset, leaves the flag unchanged.
- R10: An extension read at offset 4 returns 32'hBEBEBEBE while the flag is set and 32'h1E1E1E1E while it is clear.
- R11: `rsp_valid` is high in exactly the cycle after each read request. Writes and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ext | input | 1 | 0 selects the mode window, 1 selects the extension window |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address within the selected window |
| req_be | input | 2 | Byte lane enables for mode-window writes |
| req_wdata | input | 32 | Write data (the mode window uses bits 15:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| regs_flat | output | 16*NUM_REGS | Stored mode registers, index i at bits 16*i+15:16*i |
| big_endian | output | 1 | Framebuffer byte-order flag |

## Verification
The properties assume that the request inputs are known, are driven low throughout reset, and are sampled only at rising edges. The properties relate a request to the response or state one edge later, so they also assume nothing but the request port changes the registers. The bench changes every input only on the falling clock edge and holds `req_valid` low while reset is asserted. Extension addresses in the random phase are multiples of four up to offset 12, so both known and unknown offsets are covered. Mode addresses cover the whole address range, so reads and writes past the array occur often.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_MODE = 2'd1,
        RSP_EXT  = 2'd2
    } rsp_state_t;

    localparam logic [31:0] ORDER_MAGIC_BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] ORDER_MAGIC_LITTLE = 32'h1E1E_1E1E;

    localparam int EXT_OFF_SIZE  = 0;
    localparam int EXT_OFF_ORDER = 4;

    localparam logic [15:0] MODE_OOR_WORD = 16'hFFFF;

endpackage

// File: rtl/dmr_mode_regs.sv
module dmr_mode_regs #(
    parameter int          ADDR_W    = 6,
    parameter int          NUM_REGS  = 11,
    parameter logic [15:0] ID_VALUE  = 16'hD15A,
    parameter logic [15:0] CAP_VALUE = 16'd256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             be,
    input  logic [15:0]            wdata,
    output logic [16*NUM_REGS-1:0] regs_flat,
    output logic [15:0]            rd_word
);
    import dmr_pkg::*;

    localparam int             IDX_W   = ADDR_W - 1;
    localparam int             ID_IDX  = 0;
    localparam int             CAP_IDX = NUM_REGS - 1;
    localparam logic [IDX_W:0] LIMIT   = NUM_REGS[IDX_W:0];

    logic [IDX_W-1:0] idx;
    logic             in_range;

    assign idx      = addr[ADDR_W-1:1];
    assign in_range = ({1'b0, idx} < LIMIT);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic        hit;
        logic [15:0] q;

        assign hit = wr_en && in_range && ({1'b0, idx} == g[IDX_W:0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit) begin
                if (be[0]) q[7:0]  <= wdata[7:0];
                if (be[1]) q[15:8] <= wdata[15:8];
            end
        end

        assign regs_flat[16*g +: 16] = q;
    end

    always_comb begin
        rd_word = MODE_OOR_WORD;
        if (in_range) begin
            if ({1'b0, idx} == ID_IDX[IDX_W:0]) begin
                rd_word = ID_VALUE;
            end else if ({1'b0, idx} == CAP_IDX[IDX_W:0]) begin
                rd_word = CAP_VALUE;
            end else begin
                rd_word = '0;
                for (int i = 0; i < NUM_REGS; i++) begin
                    if ({1'b0, idx} == i[IDX_W:0]) rd_word = regs_flat[16*i +: 16];
                end
            end
        end
    end

endmodule

// File: rtl/dmr_ext_regs.sv
module dmr_ext_regs #(
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] EXT_SIZE = 32'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              big_endian,
    output logic [31:0]       rd_word
);
    import dmr_pkg::*;

    localparam logic [ADDR_W-1:0] OFF_SIZE  = EXT_OFF_SIZE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OFF_ORDER = EXT_OFF_ORDER[ADDR_W-1:0];

    logic order_hit;
    logic flag_q;

    assign order_hit = (addr == OFF_ORDER);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_en && order_hit) begin
            if (wdata == ORDER_MAGIC_BIG) begin
                flag_q <= 1'b1;
            end else if (wdata == ORDER_MAGIC_LITTLE) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign big_endian = flag_q;

    always_comb begin
        if (addr == OFF_SIZE) begin
            rd_word = EXT_SIZE;
        end else if (order_hit) begin
            rd_word = flag_q ? ORDER_MAGIC_BIG : ORDER_MAGIC_LITTLE;
        end else begin
            rd_word = '0;
        end
    end

endmodule

// File: rtl/dmr_resp_fsm.sv
module dmr_resp_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_mode,
    input  logic        rd_ext,
    input  logic [15:0] mode_word,
    input  logic [31:0] ext_word,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    import dmr_pkg::*;

    rsp_state_t state_q, state_d;
    logic [31:0] data_q;

    always_comb begin
        if (rd_mode) begin
            state_d = RSP_MODE;
        end else if (rd_ext) begin
            state_d = RSP_EXT;
        end else begin
            state_d = RSP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_mode) begin
                data_q <= {16'h0000, mode_word};
            end else if (rd_ext) begin
                data_q <= ext_word;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
            RSP_MODE: begin
                rsp_valid = 1'b1;
                rsp_data  = {16'h0000, data_q[15:0]};
            end
            RSP_EXT: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/dispmode_regs.sv
module dispmode_regs #(
    parameter int          ADDR_W   = 6,
    parameter int          NUM_REGS = 11,
    parameter logic [15:0] ID_VALUE = 16'hD15A,
    parameter int          FB_BYTES = 16777216,
    parameter logic [31:0] EXT_SIZE = 32'd8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_ext,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_be,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_data,
    output logic [16*NUM_REGS-1:0] regs_flat,
    output logic                   big_endian
);
    localparam int          CAP_UNITS = FB_BYTES / 65536;
    localparam logic [15:0] CAP_VALUE = CAP_UNITS[15:0];

    logic        mode_wr, ext_wr, mode_rd, ext_rd;
    logic [15:0] mode_word;
    logic [31:0] ext_word;

    assign mode_wr = req_valid &&  req_write && !req_ext;
    assign ext_wr  = req_valid &&  req_write &&  req_ext;
    assign mode_rd = req_valid && !req_write && !req_ext;
    assign ext_rd  = req_valid && !req_write &&  req_ext;

    dmr_mode_regs #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .ID_VALUE (ID_VALUE),
        .CAP_VALUE(CAP_VALUE)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .addr     (req_addr),
        .be       (req_be),
        .wdata    (req_wdata[15:0]),
        .regs_flat(regs_flat),
        .rd_word  (mode_word)
    );

    dmr_ext_regs #(
        .ADDR_W  (ADDR_W),
        .EXT_SIZE(EXT_SIZE)
    ) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ext_wr),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .big_endian(big_endian),
        .rd_word   (ext_word)
    );

    dmr_resp_fsm u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_mode  (mode_rd),
        .rd_ext   (ext_rd),
        .mode_word(mode_word),
        .ext_word (ext_word),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/dispmode_regs_chk.sv
module dispmode_regs_chk #(
    parameter int          ADDR_W   = 6,
    parameter int          NUM_REGS = 11,
    parameter logic [15:0] ID_VALUE = 16'hD15A
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ext,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [31:0]            req_wdata,
    input logic                   rsp_valid,
    input logic [31:0]            rsp_data,
    input logic [16*NUM_REGS-1:0] regs_flat,
    input logic                   big_endian
);
    import dmr_pkg::*;

    localparam logic [ADDR_W-1:0] LIMIT     = NUM_REGS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ORDER_OFF = EXT_OFF_ORDER[ADDR_W-1:0];

    logic [ADDR_W-1:0] idx_ext;
    logic              mode_req, ext_req, oor;

    assign idx_ext  = {1'b0, req_addr[ADDR_W-1:1]};
    assign mode_req = req_valid && !req_ext;
    assign ext_req  = req_valid &&  req_ext;
    assign oor      = (idx_ext >= LIMIT);

    // R11
    rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R11
    no_rsp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // R4
    id_read_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !req_write && idx_ext == '0) |=> (rsp_data == {16'h0000, ID_VALUE}));

    // R6
    oor_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !req_write && oor) |=> (rsp_valid && rsp_data == 32'h0000_FFFF));

    // R7
    oor_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && req_write && oor) |=> $stable(regs_flat));

    // R9
    order_other_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && req_write && (req_addr != ORDER_OFF ||
         (req_wdata != ORDER_MAGIC_BIG && req_wdata != ORDER_MAGIC_LITTLE)))
        |=> $stable(big_endian));

    // R9
    order_set_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && req_write && req_addr == ORDER_OFF && req_wdata == ORDER_MAGIC_BIG)
        |=> big_endian);

    // R10
    order_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !req_write && req_addr == ORDER_OFF)
        |=> (rsp_data == (big_endian ? ORDER_MAGIC_BIG : ORDER_MAGIC_LITTLE)));

endmodule

bind dispmode_regs dispmode_regs_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .ID_VALUE(ID_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ext   (req_ext),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .regs_flat (regs_flat),
    .big_endian(big_endian)
);

// File: tb/dispmode_regs_bench.sv
module dispmode_regs_bench;
    localparam int          PERIOD  = 10;
    localparam int          AW      = 6;
    localparam int          NREG    = 11;
    localparam logic [15:0] ID_C    = 16'hD15A;
    localparam int          CAP_C   = 256;
    localparam int          SIZE_C  = 8;
    localparam logic [31:0] MAG_BIG = 32'hBEBE_BEBE;
    localparam logic [31:0] MAG_LIT = 32'h1E1E_1E1E;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ext = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [1:0]        req_be = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic [16*NREG-1:0] regs_flat;
    logic              big_endian;

    int total = 0;
    int bad   = 0;

    dispmode_regs u_dispmode_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ext(req_ext),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .regs_flat(regs_flat), .big_endian(big_endian)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model
    int    m_regs [NREG];
    bit    m_flag;
    bit    m_vld;
    int    m_data;
    string m_rtag;
    string m_gtag;
    string m_ftag;

    always @(posedge clk) begin
        int idx;
        idx = int'(req_addr) / 2;
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_flag = 0; m_vld = 0; m_data = 0;
            m_rtag = "R1"; m_gtag = "R1"; m_ftag = "R1";
        end else begin
            m_vld = 0;
            m_rtag = "R11";
            if (req_valid && !req_write) begin
                m_vld = 1;
                if (!req_ext) begin
                    if (idx >= NREG)        begin m_data = 'hFFFF;      m_rtag = "R6"; end
                    else if (idx == 0)      begin m_data = int'(ID_C);  m_rtag = "R4"; end
                    else if (idx == NREG-1) begin m_data = CAP_C;       m_rtag = "R5"; end
                    else                    begin m_data = m_regs[idx]; m_rtag = "R3"; end
                end else begin
                    if (req_addr == 0)      begin m_data = SIZE_C; m_rtag = "R8"; end
                    else if (req_addr == 4) begin m_data = m_flag ? int'(MAG_BIG) : int'(MAG_LIT); m_rtag = "R10"; end
                    else                    begin m_data = 0;      m_rtag = "R8"; end
                end
            end else if (req_valid && req_write) begin
                if (!req_ext) begin
                    if (idx < NREG) begin
                        if (req_be[0]) m_regs[idx] = (m_regs[idx] & 'hFF00) | int'(req_wdata[7:0]);
                        if (req_be[1]) m_regs[idx] = (m_regs[idx] & 'h00FF) | (int'(req_wdata[15:8]) << 8);
                        m_gtag = "R2";
                    end else begin
                        m_gtag = "R7";
                    end
                end else begin
                    m_ftag = "R9";
                    if (req_addr == 4 && req_wdata == MAG_BIG) m_flag = 1;
                    else if (req_addr == 4 && req_wdata == MAG_LIT) m_flag = 0;
                end
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        logic [16*NREG-1:0] exp_flat;
        for (int i = 0; i < NREG; i++) exp_flat[16*i +: 16] = m_regs[i][15:0];
        total++;
        if (rsp_valid !== m_vld) begin
            bad++;
            $display("FAIL %s rsp_valid actual=%0b expected=%0b", m_vld ? m_rtag : "R11", rsp_valid, m_vld);
        end
        if (m_vld) begin
            total++;
            if (rsp_data !== m_data[31:0]) begin
                bad++;
                $display("FAIL %s rsp_data actual=%h expected=%h", m_rtag, rsp_data, m_data[31:0]);
            end
        end
        total++;
        if (regs_flat !== exp_flat) begin
            bad++;
            $display("FAIL %s regs_flat actual=%h expected=%h", m_gtag, regs_flat, exp_flat);
        end
        total++;
        if (big_endian !== m_flag) begin
            bad++;
            $display("FAIL %s big_endian actual=%0b expected=%0b", m_ftag, big_endian, m_flag);
        end
    end

    task automatic acc(input bit ext, input bit wr, input int addr, input logic [1:0] be,
                       input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_ext = ext; req_write = wr;
        req_addr = addr[AW-1:0]; req_be = be; req_wdata = data;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(PERIOD*150000);
        bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();                                  // R1 reset state observed
        acc(0, 0, 0, 2'b11, 0);                  // R4 identity read
        acc(0, 1, 0, 2'b11, 32'h1234);           // write identity index
        acc(0, 0, 1, 2'b11, 0);                  // R4 still constant (odd addr)
        acc(0, 0, 20, 2'b11, 0);                 // R5 capacity
        acc(0, 1, 20, 2'b11, 32'h7777);
        acc(0, 0, 20, 2'b11, 0);                 // R5 after write
        acc(0, 1, 2, 2'b11, 32'h0320);           // R2 full word
        acc(0, 0, 2, 2'b11, 0);                  // R3
        acc(0, 1, 6, 2'b01, 32'hABCD);           // R2 even byte only
        acc(0, 1, 7, 2'b10, 32'h12FF);           // R2 odd byte, bit 0 ignored
        acc(0, 0, 6, 2'b00, 0);                  // R3 expect 12CD
        acc(0, 1, 22, 2'b11, 32'hDEAD);          // R7
        acc(0, 1, 63, 2'b11, 32'hBEEF);          // R7
        acc(0, 0, 22, 2'b11, 0);                 // R6
        acc(1, 0, 0, 2'b11, 0);                  // R8 size
        acc(1, 0, 8, 2'b11, 0);                  // R8 unknown
        acc(1, 0, 4, 2'b11, 0);                  // R10 little
        acc(1, 1, 4, 2'b11, 32'h12345678);       // R9 other value
        acc(1, 1, 4, 2'b11, MAG_BIG);            // R9 set
        acc(1, 0, 4, 2'b11, 0);                  // R10 big
        acc(1, 1, 8, 2'b11, MAG_LIT);            // R9 wrong offset
        acc(1, 1, 4, 2'b11, MAG_LIT);            // R9 clear
        acc(1, 0, 4, 2'b11, 0);                  // R10
        idle();
        for (int n = 0; n < 4000; n++) begin
            bit          ext;
            int          sel;
            logic [31:0] d;
            ext = $urandom_range(0, 1) == 1;
            sel = $urandom_range(0, 3);
            d = (sel == 0) ? MAG_BIG : (sel == 1) ? MAG_LIT : $urandom;
            if ($urandom_range(0, 4) == 0) begin
                idle();
            end else begin
                acc(ext, $urandom_range(0, 1) == 1,
                    ext ? 4 * $urandom_range(0, 3) : $urandom_range(0, 63),
                    2'($urandom_range(0, 3)), d);
            end
        end
        idle();
        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule